// File: doc/BRIEF.md
# Tape Byte Buffer Handshake

This block is a one-byte data register that sits between a host doing programmed I/O and the byte stream of a tape drive. A single busy flag paces both directions. Its meaning depends on the direction. While reading, busy set means the register is empty and waiting for the tape. While writing, busy set means the register holds a byte the tape has not yet taken.

On a read, the tape side loads a byte at each byte time, clears busy and raises an interrupt pulse. The host then reads the byte, which sets busy again. On a write, the host loads a byte, which sets busy. At each byte time the tape side takes a held byte, clears busy and raises an interrupt. A byte time that finds the register empty marks the end of the record.

Missed bytes set a sticky error flag. A read byte that arrives before the host took the previous one sets it, and so does a host write that lands while a write operation is stopping. A start pulse arms the buffer for the chosen direction.

Top module: `tape_byte_buf`

## Requirements
- R1: After reset the data register is 0, busy is 1, error is 0, and the interrupt, consumed-byte and record-end pulses are 0.
- R2: A start pulse clears error and sets busy to 1 for a read (direction 0) or to 0 for a write (direction 1). It overrides every other input in that cycle.
- R3: In a read transfer a tape byte strobe loads the tape byte into the data register and clears busy. It pulses the interrupt for one cycle, the cycle after the strobe.
- R4: In a read transfer a host read strobe without a tape strobe sets busy.
- R5: In a read transfer a tape strobe that finds busy clear, with no host read in the same cycle, sets error. Error stays set until reset or the next start pulse. A host read in the same cycle as the strobe counts as having taken the old byte.
- R6: A host write during a transfer latches the low 8 bits of the 16-bit host word and sets busy. In a read transfer a same-cycle tape strobe wins instead.
- R7: In a write transfer a tape strobe that finds busy set presents the held byte on the tape data output and pulses the consumed-byte strobe for one cycle. It also clears busy and pulses the interrupt.
- R8: In a write transfer a tape strobe that finds busy clear pulses record-end for one cycle. It raises neither the interrupt nor the consumed-byte strobe.
- R9: In a write transfer a host write while the stopping input is 1 sets error.
- R10: Outside a transfer a host write updates only the data register. Host reads and tape strobes change nothing.
- R11: In a write transfer, when a host write and a tape strobe meet while busy is set, the old byte is consumed, the new byte is latched and busy stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Start pulse that arms the buffer for the current direction |
| xfer_on | input | 1 | Transfer in progress |
| dir_wr | input | 1 | Direction: 0 read from tape, 1 write to tape |
| stopping | input | 1 | Write operation is in its stopping phase |
| host_rd | input | 1 | Host data read strobe |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | HOST_W | Host write word; low BYTE_W bits are used |
| tape_stb | input | 1 | Tape byte-time strobe |
| tape_rdata | input | BYTE_W | Byte from the tape on reads |
| data_out | output | BYTE_W | Data register |
| busy | output | 1 | Busy flag |
| err | output | 1 | Sticky overrun error flag |
| irq | output | 1 | One-cycle interrupt pulse |
| tape_wstb | output | 1 | One-cycle pulse: byte taken by the tape on writes |
| tape_wdata | output | BYTE_W | Byte taken by the tape |
| rec_end | output | 1 | One-cycle pulse: write record ended on an empty buffer |

## Verification
The read path is swept over all 256 byte positions. The deposited value is a multiplicative pattern of the index, so a stuck or swapped data bit shows up, and each deposit is followed by a host read, which checks that busy toggles in both halves of every handshake. The write path is swept the same way with nonzero high host bits, so latching the wrong slice of the host word is caught. The consumed byte is compared with the one written before it. The remaining cases tell apart the decisions that hinge on the state before the edge: a strobe on an empty versus a full buffer, an overrun versus a same-cycle host read, a host write with and without stopping, and a host write meeting a strobe. Idle stimuli are checked to leave busy, error and the data register alone.

// File: rtl/tbuf_pkg.sv
// Package: shared types for the tape byte buffer.
// Assumes: one step record per direction, merged by the top module.
package tbuf_pkg;
    // Next-state decision made by one direction path for one clock.
    typedef struct packed {
        logic ld_host;   // load data register from host word
        logic ld_tape;   // load data register from tape byte
        logic busy;      // next busy value
        logic err_set;   // raise the sticky error flag
        logic irq;       // interrupt pulse
        logic wstb;      // tape takes the held byte
        logic rec_end;   // write record ends on empty buffer
    } tbuf_step_t;
endpackage

// File: rtl/tbuf_rd_path.sv
// Module: read-direction decision logic.
// Busy set means the register is empty. A tape strobe always deposits;
// a host read in the same cycle counts as having taken the old byte.
// Assumes: used only while a read transfer is in progress.
module tbuf_rd_path
    import tbuf_pkg::*;
(
    input  logic       busy_q,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic       tape_stb,
    output tbuf_step_t step
);
    // Purpose: decide the read-direction next state.
    always_comb begin
        step         = '0;
        step.ld_tape = tape_stb;
        step.ld_host = host_wr && !tape_stb;
        step.irq     = tape_stb;
        step.err_set = tape_stb && !busy_q && !host_rd;
        if (tape_stb)
            step.busy = 1'b0;
        else if (host_rd || host_wr)
            step.busy = 1'b1;
        else
            step.busy = busy_q;
    end
endmodule

// File: rtl/tbuf_wr_path.sv
// Module: write-direction decision logic.
// Busy set means the register holds a byte. The tape strobe judges the
// busy state before the edge; a host write in the same cycle lands after.
// Assumes: used only while a write transfer is in progress.
module tbuf_wr_path
    import tbuf_pkg::*;
(
    input  logic       busy_q,
    input  logic       host_wr,
    input  logic       stopping,
    input  logic       tape_stb,
    output tbuf_step_t step
);
    // Purpose: decide the write-direction next state.
    always_comb begin
        step         = '0;
        step.ld_host = host_wr;
        step.wstb    = tape_stb && busy_q;
        step.irq     = tape_stb && busy_q;
        step.rec_end = tape_stb && !busy_q;
        step.err_set = host_wr && stopping;
        if (host_wr)
            step.busy = 1'b1;
        else if (tape_stb && busy_q)
            step.busy = 1'b0;
        else
            step.busy = busy_q;
    end
endmodule

// File: rtl/tape_byte_buf.sv
// Module: one-byte data buffer between host programmed I/O and a tape
// byte stream, with direction-dependent busy flow control and a sticky
// overrun error. Assumes all strobes are one-cycle and synchronous to clk;
// reset is synchronous and active low.
module tape_byte_buf
    import tbuf_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned HOST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_on,
    input  logic              dir_wr,
    input  logic              stopping,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              tape_stb,
    input  logic [BYTE_W-1:0] tape_rdata,
    output logic [BYTE_W-1:0] data_out,
    output logic              busy,
    output logic              err,
    output logic              irq,
    output logic              tape_wstb,
    output logic [BYTE_W-1:0] tape_wdata,
    output logic              rec_end
);
    localparam int unsigned HI_W = HOST_W - BYTE_W;

    logic [BYTE_W-1:0] data_q, wbyte_q;
    logic              busy_q, err_q, irq_q, wstb_q, rend_q;
    tbuf_step_t        rd_step, wr_step, step;
    logic [BYTE_W-1:0] host_byte;
    logic [HI_W-1:0]   unused_hi;

    assign host_byte = host_wdata[BYTE_W-1:0];
    assign unused_hi = host_wdata[HOST_W-1:BYTE_W];

    tbuf_rd_path u_rd (
        .busy_q   (busy_q),
        .host_rd  (host_rd),
        .host_wr  (host_wr),
        .tape_stb (tape_stb),
        .step     (rd_step)
    );

    tbuf_wr_path u_wr (
        .busy_q   (busy_q),
        .host_wr  (host_wr),
        .stopping (stopping),
        .tape_stb (tape_stb),
        .step     (wr_step)
    );

    // Purpose: pick the active direction, or the idle behaviour outside a transfer.
    always_comb begin
        if (!xfer_on) begin
            step         = '0;
            step.ld_host = host_wr;
            step.busy    = busy_q;
        end else if (dir_wr) begin
            step = wr_step;
        end else begin
            step = rd_step;
        end
    end

    // Purpose: hold the buffer state and the one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            wbyte_q <= '0;
            busy_q  <= 1'b1;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            wstb_q  <= 1'b0;
            rend_q  <= 1'b0;
        end else if (xfer_start) begin
            busy_q  <= !dir_wr;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            wstb_q  <= 1'b0;
            rend_q  <= 1'b0;
        end else begin
            if (step.ld_tape)
                data_q <= tape_rdata;
            else if (step.ld_host)
                data_q <= host_byte;
            if (step.wstb)
                wbyte_q <= data_q;
            busy_q <= step.busy;
            err_q  <= err_q || step.err_set;
            irq_q  <= step.irq;
            wstb_q <= step.wstb;
            rend_q <= step.rec_end;
        end
    end

    assign data_out   = data_q;
    assign tape_wdata = wbyte_q;
    assign busy       = busy_q;
    assign err        = err_q;
    assign irq        = irq_q;
    assign tape_wstb  = wstb_q;
    assign rec_end    = rend_q;
endmodule

// File: rtl/tape_byte_buf_chk.sv
// Module: property checker for tape_byte_buf, attached by bind.
// Assumes: observes only the top-level ports.
module tape_byte_buf_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned HOST_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_start,
    input logic              xfer_on,
    input logic              dir_wr,
    input logic              stopping,
    input logic              host_rd,
    input logic              host_wr,
    input logic [HOST_W-1:0] host_wdata,
    input logic              tape_stb,
    input logic [BYTE_W-1:0] tape_rdata,
    input logic [BYTE_W-1:0] data_out,
    input logic              busy,
    input logic              err,
    input logic              irq,
    input logic              tape_wstb,
    input logic [BYTE_W-1:0] tape_wdata,
    input logic              rec_end
);
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (!err && busy == !$past(dir_wr))); // R2

    AST_RD_DEPOSIT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && !dir_wr && tape_stb && !xfer_start)
        |=> (!busy && irq && data_out == $past(tape_rdata))); // R3

    AST_RD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && !dir_wr && host_rd && !tape_stb && !xfer_start) |=> busy); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !xfer_start) |=> err); // R5

    AST_WR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && dir_wr && host_wr && !xfer_start)
        |=> (busy && data_out == $past(host_wdata[BYTE_W-1:0]))); // R6

    AST_WR_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && dir_wr && tape_stb && busy && !xfer_start)
        |=> (tape_wstb && irq && !rec_end && tape_wdata == $past(data_out))); // R7

    AST_REC_END: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && dir_wr && tape_stb && !busy && !xfer_start)
        |=> (rec_end && !tape_wstb && !irq)); // R8

    AST_WR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && dir_wr && host_wr && stopping && !xfer_start) |=> err); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_on && !xfer_start) |=> ($stable(busy) && $stable(err) && !irq)); // R10

    // Purpose: the two tape-side pulses never coincide.
    always @(posedge clk) begin
        if (rst_n)
            AST_PULSE_EXCL: assert (!(tape_wstb && rec_end)); // R8
    end
endmodule

bind tape_byte_buf tape_byte_buf_chk #(.BYTE_W(BYTE_W), .HOST_W(HOST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_on(xfer_on),
    .dir_wr(dir_wr), .stopping(stopping), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .tape_stb(tape_stb), .tape_rdata(tape_rdata),
    .data_out(data_out), .busy(busy), .err(err), .irq(irq),
    .tape_wstb(tape_wstb), .tape_wdata(tape_wdata), .rec_end(rec_end)
);

// File: tb/tape_byte_buf_test.sv
// Bench: sweeps both directions of tape_byte_buf and checks each cycle's
// outputs against values computed from the requirements.
module tape_byte_buf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_on = 1'b0, dir_wr = 1'b0, stopping = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0, tape_stb = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [7:0]  tape_rdata = '0;
    logic [7:0]  data_out, tape_wdata;
    logic        busy, err, irq, tape_wstb, rec_end;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tape_byte_buf uut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_on(xfer_on),
        .dir_wr(dir_wr), .stopping(stopping), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .tape_stb(tape_stb), .tape_rdata(tape_rdata),
        .data_out(data_out), .busy(busy), .err(err), .irq(irq),
        .tape_wstb(tape_wstb), .tape_wdata(tape_wdata), .rec_end(rec_end)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock with the strobes currently driven; strobes drop after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        xfer_start = 0; host_rd = 0; host_wr = 0; tape_stb = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 data", data_out, 0);  chk("R1 busy", busy, 1);
        chk("R1 err", err, 0);        chk("R1 irq", irq, 0);
        chk("R1 wstb", tape_wstb, 0); chk("R1 rec_end", rec_end, 0);

        // R10 idle: host write changes data only; strobes and reads ignored
        host_wr = 1; host_wdata = 16'hA55A; tick();
        chk("R10 idle data", data_out, 8'h5A); chk("R10 idle busy", busy, 1);
        tape_stb = 1; tape_rdata = 8'h33; tick();
        chk("R10 idle stb data", data_out, 8'h5A); chk("R10 idle irq", irq, 0);
        host_rd = 1; tick();
        chk("R10 idle rd busy", busy, 1); chk("R10 idle err", err, 0);

        // R2 read start
        dir_wr = 0; xfer_on = 1; xfer_start = 1; tape_stb = 1; tick();
        chk("R2 rd busy", busy, 1); chk("R2 rd err", err, 0);
        chk("R2 start overrides stb", irq, 0);

        // R3/R4 read sweep
        for (int i = 0; i < 256; i++) begin
            tape_stb = 1; tape_rdata = 8'((i * 37 + 11) & 255); tick();
            chk("R3 data", data_out, (i * 37 + 11) & 255);
            chk("R3 busy", busy, 0); chk("R3 irq", irq, 1);
            host_rd = 1; tick();
            chk("R3 irq pulse", irq, 0); chk("R4 busy", busy, 1);
            chk("R5 no overrun", err, 0);
        end

        // R5 overrun: second strobe with no read
        tape_stb = 1; tape_rdata = 8'h10; tick();
        tape_stb = 1; tape_rdata = 8'h20; tick();
        chk("R5 overrun err", err, 1); chk("R5 newest data", data_out, 8'h20);
        tick();
        chk("R5 sticky", err, 1);

        // R5 same-cycle read is not an overrun
        xfer_start = 1; tick();
        chk("R2 restart clears err", err, 0);
        tape_stb = 1; tape_rdata = 8'h44; tick();
        tape_stb = 1; host_rd = 1; tape_rdata = 8'h55; tick();
        chk("R5 rd same cycle err", err, 0); chk("R5 rd same cycle data", data_out, 8'h55);
        chk("R5 rd same cycle busy", busy, 0);

        // R2 write start
        dir_wr = 1; xfer_start = 1; tick();
        chk("R2 wr busy", busy, 0); chk("R2 wr err", err, 0);

        // R6/R7 write sweep
        for (int i = 0; i < 256; i++) begin
            host_wr = 1; host_wdata = {8'(i ^ 8'hC3), 8'((i * 53 + 7) & 255)}; tick();
            chk("R6 data", data_out, (i * 53 + 7) & 255); chk("R6 busy", busy, 1);
            chk("R6 no wstb", tape_wstb, 0);
            tape_stb = 1; tick();
            chk("R7 wstb", tape_wstb, 1); chk("R7 wdata", tape_wdata, (i * 53 + 7) & 255);
            chk("R7 busy", busy, 0); chk("R7 irq", irq, 1);
            chk("R9 no err", err, 0);
        end

        // R8 empty buffer ends the record
        tape_stb = 1; tick();
        chk("R8 rec_end", rec_end, 1); chk("R8 wstb", tape_wstb, 0); chk("R8 irq", irq, 0);
        tick();
        chk("R8 pulse", rec_end, 0);

        // R11 host write meets tape strobe with buffer full
        host_wr = 1; host_wdata = 16'h0111; tick();
        host_wr = 1; host_wdata = 16'h0222; tape_stb = 1; tick();
        chk("R11 wstb", tape_wstb, 1); chk("R11 wdata old", tape_wdata, 8'h11);
        chk("R11 data new", data_out, 8'h22); chk("R11 busy", busy, 1);
        tape_stb = 1; tick();
        chk("R11 second wdata", tape_wdata, 8'h22); chk("R11 drained", busy, 0);

        // R9 write overrun while stopping
        stopping = 1; host_wr = 1; host_wdata = 16'h0077; tick();
        chk("R9 err", err, 1); chk("R9 data", data_out, 8'h77);
        stopping = 0;

        // R10 leaving the transfer keeps err and busy
        xfer_on = 0; tape_stb = 1; host_wr = 1; host_wdata = 16'h0099; tick();
        chk("R10 out data", data_out, 8'h99); chk("R10 out busy", busy, 1);
        chk("R10 out err", err, 1); chk("R10 out wstb", tape_wstb, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule